// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs PHY management transactions over a two-wire serial management bus of the Clause 22 kind. Software builds one complete management frame in a single 32-bit maintenance word and writes it through a small register port. The block then sends a run of preamble ones followed by the 32 bits of the word, most significant bit first, on a divided management clock. For a read, the block lets go of the data line for the turnaround and data bits and samples what the PHY drives. When the frame ends, the 16 sampled bits overwrite the low half of the maintenance word, where software reads them.

Fixed fields of the maintenance word, most significant first: bit 31 = 0 and bit 30 = 1 (start code), bits 29:28 the operation (2'b10 read, 2'b01 write), bits 27:23 the PHY address, bits 22:18 the register address, bits 17:16 the turnaround pattern 2'b10, bits 15:0 the data. The block does not interpret the upper half. It sends it exactly as written, so software always includes the constant 0x40020000. A status register has an idle flag at bit 2, and software polls it before and after each operation. An enable input gates all bus activity.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset the idle flag (status bit 2, read with `reg_sel`=1) is 1, `mdc` is 0, `mdio_oe` is 0 and the maintenance word (read with `reg_sel`=0) is 0.
- R2: Every frame is PRE_LEN ones followed by maintenance bits 31 down to 0, one bit per `mdc` period, with `mdio_oe` high for every bit that the block drives.
- R3: `mdc` runs at the block clock divided by CLK_DIV, high for CLK_DIV/2 cycles of each period, and stays 0 while no frame is in progress.
- R4: `mdio_o` changes only on the clock edge where `mdc` falls (or, for the first bit, when the frame starts while `mdc` is 0), so it is stable whenever `mdc` rises.
- R5: For a read (bits 29:28 = 2'b10), `mdio_oe` is 0 for the two turnaround bits and the 16 data bits, that is, for the last 18 bits of the frame.
- R6: For a read, `mdio_i` is sampled on each of the 16 `mdc` rising edges of the data phase, first bit to bit 15. At the end of the frame these bits replace bits 15:0 of the maintenance word, and bits 31:16 keep their value.
- R7: A read with no PHY answering, where `mdio_i` stays 1, returns 0xFFFF in bits 15:0.
- R8: The idle flag goes to 0 on the cycle after the maintenance write and returns to 1 after exactly (PRE_LEN+32)*CLK_DIV enabled clock cycles.
- R9: A write to the maintenance word while a frame is in progress is ignored: it changes neither the frame on the bus nor the word read back.
- R10: While `mgmt_en` is 0, an accepted frame waits with `mdc` at 0 and the idle flag at 0. It proceeds normally once `mgmt_en` is 1.
- R11: After a frame with any operation other than read, the maintenance word reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management port enable; bus activity is held while 0 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the maintenance word, 1 the status register (read-only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Divided management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with CLK_DIV=6 and PRE_LEN=4. A whole frame is then 216 cycles, so one run can include writes, reads with several data patterns, a read with no PHY, a blocked write during a frame and a frame stalled by the enable. The smaller divider keeps the half-period of three cycles, and with it the exact edge where `mdio_o` may change and `mdio_i` is sampled, which shows up every misplaced bit. The short preamble still exercises the preamble-to-frame boundary. The turnaround position does not depend on it, so the release of the output enable is checked at the same offsets as with the default values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] OPC_READ     = 2'b10;
  localparam int         STAT_IDLE_BIT = 2;
  localparam int         WORD_W       = 32;
  localparam int         DATA_W       = 16;

  // opcode field of the maintenance word
  function automatic logic op_is_read(input logic [31:0] w);
    return w[29:28] == OPC_READ;
  endfunction

  // level on the line for frame position pos (preamble first)
  function automatic logic bit_at(input logic [31:0] w, input int pre, input int pos);
    if (pos < pre) return 1'b1;
    return w[5'(31 - (pos - pre))];
  endfunction

  // output enable for frame position pos: released from turnaround on for reads
  function automatic logic oe_at(input logic rd, input int pre, input int pos);
    return !(rd && (pos >= pre + 14));
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enable,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;
  logic          run;

  assign run      = active && enable;
  assign rise_stb = run && (cnt == CW'(HALF - 1));
  assign fall_stb = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (enable) begin
      cnt <= fall_stb ? '0 : cnt + 1'b1;
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end

  // R3
  mdc_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> active);

  // R10
  mdc_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(mdc));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] word,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_done,
  output logic [15:0] rd_data
);
  localparam int TOTAL = PRE + WORD_W;
  localparam int IW    = $clog2(TOTAL + 1);

  logic [IW-1:0] idx;
  logic [IW-1:0] nxt;
  logic [31:0]   word_q;
  logic          rd_q;
  logic          sample_evt;

  assign nxt        = idx + 1'b1;
  assign frame_done = busy && fall_stb && (idx == IW'(TOTAL - 1));
  assign sample_evt = busy && rise_stb && rd_q && (int'(idx) >= PRE + 16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      word_q  <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      idx     <= '0;
      word_q  <= word;
      rd_q    <= op_is_read(word);
      mdio_o  <= bit_at(word, PRE, 0);
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (sample_evt) rd_data <= {rd_data[14:0], mdio_i};
      if (frame_done) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b1;
      end else if (fall_stb) begin
        idx     <= nxt;
        mdio_o  <= bit_at(word_q, PRE, int'(nxt));
        mdio_oe <= oe_at(rd_q, PRE, int'(nxt));
      end
    end
  end

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && int'(idx) >= PRE + 14) |-> !mdio_oe);

  // R8
  done_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  // R2
  drive_when_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 48,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mgmt_en,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0] maint_q;
  logic        busy;
  logic        start;
  logic        frame_done;
  logic        rise_stb;
  logic        fall_stb;
  logic [15:0] rd_data;
  logic [31:0] status_word;

  assign start = reg_wr_en && !reg_sel && !busy;

  always_comb begin
    status_word                = '0;
    status_word[STAT_IDLE_BIT] = !busy;
  end

  assign reg_rdata = reg_sel ? status_word : maint_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               maint_q <= '0;
    else if (start)                           maint_q <= reg_wdata;
    else if (frame_done && op_is_read(maint_q)) maint_q[15:0] <= rd_data;
  end

  mdio_clk_div #(.DIV(CLK_DIV)) clk_div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .enable   (mgmt_en),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_shifter #(.PRE(PRE_LEN)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word       (reg_wdata),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .frame_done (frame_done),
    .rd_data    (rd_data)
  );

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en && !reg_sel && !frame_done) |=> $stable(maint_q));

  // R4
  data_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

  // R11
  write_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !op_is_read(maint_q)) |=> $stable(maint_q));

endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
`timescale 1ns/100ps
module mdio_frame_ctrl_tb_top;
  localparam int TB_DIV = 6;
  localparam int TB_PRE = 4;
  localparam int TOTAL  = TB_PRE + 32;
  localparam int FRAME_CYC = TOTAL * TB_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_en = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int n_cmp = 0;
  int n_bad = 0;
  int mon_cnt = 0;
  int base_cnt = 0;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_val = 16'hFFFF;
  logic [2:0]  exp_q[$];

  always #2.5 clk = ~clk;

  mdio_frame_ctrl #(.CLK_DIV(TB_DIV), .PRE_LEN(TB_PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return 32'h4002_0000 | (32'(op) << 28) | (32'(phy) << 23) | (32'(rg) << 18) | 32'(d);
  endfunction

  // scoreboard monitor: one expected {checked, oe, level} per MDC rise (R2, R5, R4)
  initial begin
    forever begin
      @(posedge mdc);
      #1;
      mon_cnt++;
      if (exp_q.size() == 0) begin
        check("R3", "unexpected mdc rise", 32'(mdc), 32'd0);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check("R5", "mdio_oe per bit", 32'(mdio_oe), 32'(e[1]));
        if (e[2]) check("R2", "mdio_o per bit", 32'(mdio_o), 32'(e[0]));
      end
    end
  end

  // MDC high phase length (R3)
  initial begin
    forever begin
      realtime t0;
      @(posedge mdc);
      t0 = $realtime;
      @(negedge mdc);
      check("R3", "mdc high time x10ns", 32'(int'(($realtime - t0) * 10.0)), 32'(TB_DIV / 2 * 50));
    end
  end

  // PHY model: drives the next bit after each MDC fall
  initial begin
    mdio_i = 1'b1;
    forever begin
      int k;
      @(negedge mdc);
      #1;
      k = mon_cnt - base_cnt;
      if (phy_rd && k >= TB_PRE + 16 && k < TOTAL)
        mdio_i = phy_val[15 - (k - TB_PRE - 16)];
      else
        mdio_i = 1'b1;
    end
  end

  task automatic push_frame(input logic [31:0] w);
    logic rd;
    rd = (w[29:28] == 2'b10);
    for (int i = 0; i < TB_PRE; i++) exp_q.push_back(3'b111);
    for (int j = 0; j < 32; j++) begin
      if (rd && j >= 14) exp_q.push_back(3'b000);
      else               exp_q.push_back({2'b11, w[31 - j]});
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, input logic present, input logic [15:0] pv,
                           input logic [31:0] expect_word, input int hold, input logic inject);
    logic [31:0] v;
    int n;
    @(negedge clk);
    base_cnt = mon_cnt;
    phy_rd   = (w[29:28] == 2'b10) && present;
    phy_val  = pv;
    push_frame(w);
    if (hold > 0) mgmt_en = 1'b0;
    reg_wr_en = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr_en = 1'b0;
    read_reg(1'b1, v);
    check("R8", "idle after write", 32'(v[2]), 32'd0);
    n = 0;
    while (1) begin
      read_reg(1'b1, v);
      if (v[2]) break;
      n++;
      if (hold > 0 && n <= hold) begin
        check("R10", "mdc held low", 32'(mdc), 32'd0);
        if (n == hold) mgmt_en = 1'b1;
      end
      if (inject && n == 20) begin
        reg_wr_en = 1'b1;
        reg_wdata = ~w;
      end
      if (inject && n == 21) reg_wr_en = 1'b0;
      @(negedge clk);
    end
    check("R8", "busy cycles", 32'(n), 32'(FRAME_CYC + ((hold > 0) ? hold - 1 : 0)));
    check("R2", "bits left unsent", 32'(exp_q.size()), 32'd0);
    check("R3", "mdc low when idle", 32'(mdc), 32'd0);
    read_reg(1'b0, v);
    check(inject ? "R9" : (w[29:28] == 2'b10 ? "R6" : "R11"), "maintenance readback", v, expect_word);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_reg(1'b1, v);
    check("R1", "idle flag", 32'(v[2]), 32'd1);
    check("R1", "mdc", 32'(mdc), 32'd0);
    check("R1", "mdio_oe", 32'(mdio_oe), 32'd0);
    read_reg(1'b0, v);
    check("R1", "maintenance word", v, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 write frame
    w = mk(2'b01, 5'd5, 5'd3, 16'hA5C3);
    run_frame(w, 1'b1, 16'h0000, w, 0, 1'b0);
    // R6 read frames with several patterns
    w = mk(2'b10, 5'd31, 5'd1, 16'h0000);
    run_frame(w, 1'b1, 16'h1808, {w[31:16], 16'h1808}, 0, 1'b0);
    w = mk(2'b10, 5'd0, 5'd31, 16'h00FF);
    run_frame(w, 1'b1, 16'h8001, {w[31:16], 16'h8001}, 0, 1'b0);
    // R7 no PHY answer
    w = mk(2'b10, 5'd9, 5'd2, 16'h0000);
    run_frame(w, 1'b0, 16'h0000, {w[31:16], 16'hFFFF}, 0, 1'b0);
    // R9 write during busy ignored
    w = mk(2'b10, 5'd17, 5'd9, 16'h0000);
    run_frame(w, 1'b1, 16'h1234, {w[31:16], 16'h1234}, 0, 1'b1);
    // R10 enable held low then released
    w = mk(2'b01, 5'd1, 5'd30, 16'h5A0F);
    run_frame(w, 1'b1, 16'h0000, w, 15, 1'b0);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule